// File: doc/BRIEF.md
# Wired-AND Self-Selecting Priority Arbiter

This block chooses one winner among a set of requesters by letting each of them bid on a shared arbitration bus, most significant bit first. Every bus line behaves as a wired-AND with a pull-up. A line reads 1 unless at least one requester pulls it to 0. On each bit, a requester that still matches the bits already decided, and whose own bit is 0, pulls the line low. A requester that has already lost a higher bit, or whose own bit is 1, leaves the line released. When all bits are decided, the bus holds the numerically smallest priority. The requester that carries that value receives the grant.

Priorities are 5-bit values. Zero is the most urgent level. The all-ones value means that the requester is not asking for the bus. A start strobe captures all priorities. Resolution then runs one bit per clock, so no combinational loop forms through the bus. A one-cycle valid pulse closes the round and carries a one-hot grant vector. When several requesters share the winning value, the lowest index wins. When nobody requests, the grant vector stays zero.

Top module: `wand_prio_arb`

## Requirements
- R1: After reset, `grant` is 0, `valid` is 0, `busy` is 0 and `bus_value` is all ones.
- R2: A `start` that is high at a clock edge while `busy` is 0 captures every requester's priority. From the next cycle, `busy` is 1 and `bus_value` is all ones. Changes on `prio_flat` after the capture edge have no effect on that round.
- R3: Bits are resolved one per cycle from the most significant bit down. After k edges following the capture edge, the top k bits of `bus_value` equal the top k bits of the result, and the lower bits still read 1. `valid` is high only in the cycle after the PRIO_W-th such edge, and `busy` is 0 in that cycle.
- R4: At bit i, a requester pulls the line low when its bits above i equal the bus bits above i and its own bit i is 0. Otherwise it releases the line. A line reads 0 only when at least one requester pulls it low. The final `bus_value` is the minimum of all captured priorities.
- R5: While `valid` is high, `grant` has exactly one bit set, at the lowest requester index whose captured priority equals `bus_value`. This applies whenever that value is not all ones.
- R6: If every captured priority is all ones (31 at the default width), `valid` still pulses, `bus_value` is all ones and `grant` is 0.
- R7: A `start` that is high while `busy` is 1 is ignored. The running round completes at its original time, and no second round follows.
- R8: `grant` is 0 in every cycle where `valid` is 0. `bus_value` keeps the round's result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a round; priorities are captured at this edge |
| prio_flat | input | NUM_REQ*PRIO_W | Requester j's priority occupies bits [j*PRIO_W +: PRIO_W] |
| busy | output | 1 | A round is resolving |
| valid | output | 1 | One-cycle pulse marking the round's result |
| grant | output | NUM_REQ | One-hot winner, zero when no request |
| bus_value | output | PRIO_W | Current arbitration bus lines |

## Verification
The bench builds the block with its defaults: eight requesters and 5-bit priorities. At this size, all-request, no-request, tie and extreme-index cases are all cheap to reach. Priority sets are drawn over the full range and also over a narrow range. The narrow range forces frequent ties and bit-by-bit eliminations deep into the low bits. The partial bus value is checked on every resolving cycle against the prefix of a software minimum. Rounds that change `prio_flat` and pulse `start` mid-round confirm that the captured set governs the result.

// File: rtl/wand_arb_pkg.sv
package wand_arb_pkg;

    typedef enum logic {
        SEQ_IDLE    = 1'b0,
        SEQ_RESOLVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic last;
        logic capture;
        logic busy;
    } seq_flags_t;

endpackage

// File: rtl/wand_req_slice.sv
module wand_req_slice #(
    parameter int PRIO_W = 5,
    localparam int IDX_W = (PRIO_W > 1) ? $clog2(PRIO_W) : 1
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] bus,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              pull_low
);
    logic hi_eq;

    always_comb begin
        hi_eq = 1'b1;
        for (int j = 0; j < PRIO_W; j++) begin
            if (j > int'(bit_idx) && prio[j] != bus[j]) begin
                hi_eq = 1'b0;
            end
        end
        pull_low = hi_eq & ~prio[bit_idx];
    end

endmodule

// File: rtl/wand_grant_pick.sv
module wand_grant_pick #(
    parameter int NUM_REQ = 8,
    parameter int PRIO_W  = 5
) (
    input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         bus,
    output logic [NUM_REQ-1:0]        grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        if (bus != {PRIO_W{1'b1}}) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                if (!found && prio_flat[i*PRIO_W +: PRIO_W] == bus) begin
                    grant[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wand_arb_seq.sv
module wand_arb_seq
    import wand_arb_pkg::*;
#(
    parameter int PRIO_W = 5,
    localparam int IDX_W = (PRIO_W > 1) ? $clog2(PRIO_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bus_bit,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [PRIO_W-1:0] bus_q,
    output logic [PRIO_W-1:0] bus_d,
    output seq_flags_t        flags
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(PRIO_W - 1);

    seq_state_e state_q;

    always_comb begin
        bus_d          = bus_q;
        bus_d[bit_idx] = bus_bit;
        flags.busy     = (state_q == SEQ_RESOLVE);
        flags.capture  = (state_q == SEQ_IDLE) && start;
        flags.last     = (state_q == SEQ_RESOLVE) && (bit_idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            bit_idx <= '0;
            bus_q   <= '1;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RESOLVE;
                        bit_idx <= TOP_IDX;
                        bus_q   <= '1;
                    end
                end
                SEQ_RESOLVE: begin
                    bus_q <= bus_d;
                    if (bit_idx == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wand_prio_arb.sv
module wand_prio_arb
    import wand_arb_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int PRIO_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
    output logic                      busy,
    output logic                      valid,
    output logic [NUM_REQ-1:0]        grant,
    output logic [PRIO_W-1:0]         bus_value
);
    localparam int IDX_W = (PRIO_W > 1) ? $clog2(PRIO_W) : 1;

    logic [NUM_REQ*PRIO_W-1:0] prio_lat;
    logic [NUM_REQ-1:0]        pull_low;
    logic [IDX_W-1:0]          bit_idx;
    logic [PRIO_W-1:0]         bus_q;
    logic [PRIO_W-1:0]         bus_d;
    logic [NUM_REQ-1:0]        grant_d;
    logic [NUM_REQ-1:0]        grant_q;
    logic                      valid_q;
    logic                      bus_bit;
    seq_flags_t                flags;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        wand_req_slice #(.PRIO_W(PRIO_W)) u_slice (
            .prio     (prio_lat[g*PRIO_W +: PRIO_W]),
            .bus      (bus_q),
            .bit_idx  (bit_idx),
            .pull_low (pull_low[g])
        );
    end

    // Wired-AND line with pull-up: high unless some requester pulls it low.
    assign bus_bit = ~|pull_low;

    wand_arb_seq #(.PRIO_W(PRIO_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bus_bit (bus_bit),
        .bit_idx (bit_idx),
        .bus_q   (bus_q),
        .bus_d   (bus_d),
        .flags   (flags)
    );

    wand_grant_pick #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) u_pick (
        .prio_flat (prio_lat),
        .bus       (bus_d),
        .grant     (grant_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_lat <= '1;
            grant_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (flags.capture) begin
                prio_lat <= prio_flat;
            end
            valid_q <= flags.last;
            grant_q <= flags.last ? grant_d : '0;
        end
    end

    assign busy      = flags.busy;
    assign valid     = valid_q;
    assign grant     = grant_q;
    assign bus_value = bus_q;

endmodule

// File: rtl/wand_prio_arb_chk.sv
module wand_prio_arb_chk #(
    parameter int NUM_REQ = 8,
    parameter int PRIO_W  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               valid,
    input logic [NUM_REQ-1:0] grant,
    input logic [PRIO_W-1:0]  bus_value
);

    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> valid);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r3_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> valid);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r4_bus_monotone: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (bus_value <= $past(bus_value)));

    a_r6_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (valid && bus_value == {PRIO_W{1'b1}}) |-> (grant == '0));

    a_r5_request_granted: assert property (@(posedge clk) disable iff (rst)
        (valid && bus_value != {PRIO_W{1'b1}}) |-> (grant != '0));

endmodule

bind wand_prio_arb wand_prio_arb_chk #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .valid     (valid),
    .grant     (grant),
    .bus_value (bus_value)
);

// File: tb/tb_wand_prio_arb.sv
module tb_wand_prio_arb;
    localparam int N = 8;
    localparam int W = 5;
    localparam logic [W-1:0] NOREQ = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [N*W-1:0]   prio_flat = '1;
    logic             busy;
    logic             valid;
    logic [N-1:0]     grant;
    logic [W-1:0]     bus_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wand_prio_arb #(.NUM_REQ(N), .PRIO_W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .prio_flat(prio_flat),
        .busy(busy), .valid(valid), .grant(grant), .bus_value(bus_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_min(input logic [N*W-1:0] p);
        logic [W-1:0] m = '1;
        for (int i = 0; i < N; i++) if (p[i*W +: W] < m) m = p[i*W +: W];
        return m;
    endfunction

    function automatic logic [N-1:0] ref_grant(input logic [N*W-1:0] p);
        logic [W-1:0] m = ref_min(p);
        if (m == NOREQ) return '0;
        for (int i = 0; i < N; i++) if (p[i*W +: W] == m) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [W-1:0] ref_partial(input logic [W-1:0] m, input int k);
        logic [W-1:0] hm = '0;
        for (int b = 0; b < W; b++) if (b >= W - k) hm[b] = 1'b1;
        return (m & hm) | ~hm;
    endfunction

    // One round; disturb changes prio_flat and pulses start while busy (R2, R7).
    task automatic run_round(input logic [N*W-1:0] p, input bit disturb);
        logic [W-1:0] m = ref_min(p);
        logic [N-1:0] g = ref_grant(p);
        @(negedge clk);
        prio_flat = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
        chk(bus_value === NOREQ, "R2 bus preset", 32'(bus_value), 32'(NOREQ));
        if (disturb) begin
            prio_flat = ~p;
            start = 1'b1;
        end
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(bus_value === ref_partial(m, k), "R3 R4 bus prefix", 32'(bus_value), 32'(ref_partial(m, k)));
            if (k < W) begin
                chk(valid === 1'b0, "R3 no early valid", 32'(valid), 0);
                chk(grant === '0, "R8 grant quiet", 32'(grant), 0);
            end
        end
        chk(valid === 1'b1 && busy === 1'b0, "R3 valid timing", {30'd0, valid, busy}, 32'h2);
        chk(bus_value === m, "R4 minimum", 32'(bus_value), 32'(m));
        if (m == NOREQ)
            chk(grant === '0, "R6 no grant", 32'(grant), 0);
        else
            chk(grant === g, "R5 winner", 32'(grant), 32'(g));
        @(negedge clk);
        chk(valid === 1'b0 && busy === 1'b0, "R7 no extra round", {30'd0, valid, busy}, 0);
        chk(grant === '0, "R8 grant cleared", 32'(grant), 0);
        chk(bus_value === m, "R8 result held", 32'(bus_value), 32'(m));
    endtask

    function automatic logic [N*W-1:0] all_same(input logic [W-1:0] v);
        logic [N*W-1:0] p;
        for (int i = 0; i < N; i++) p[i*W +: W] = v;
        return p;
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [N*W-1:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(grant === '0, "R1 reset grant", 32'(grant), 0);
        chk(valid === 1'b0, "R1 reset valid", 32'(valid), 0);
        chk(busy === 1'b0, "R1 reset busy", 32'(busy), 0);
        chk(bus_value === NOREQ, "R1 reset bus", 32'(bus_value), 32'(NOREQ));

        // R6: nobody requests
        run_round(all_same(NOREQ), 1'b0);
        // R5: full tie at zero, index 0 wins
        run_round(all_same('0), 1'b0);
        // R5: tie at 9 between requesters 3 and 6
        p = all_same(5'd20); p[3*W +: W] = 5'd9; p[6*W +: W] = 5'd9;
        run_round(p, 1'b0);
        // R5: only the last requester asks
        p = all_same(NOREQ); p[(N-1)*W +: W] = 5'd30;
        run_round(p, 1'b0);
        // R4: values differing only in bit 0
        p = all_same(NOREQ); p[1*W +: W] = 5'd17; p[2*W +: W] = 5'd16;
        run_round(p, 1'b0);
        // R2, R7: inputs disturbed mid-round
        p = all_same(5'd12); p[5*W +: W] = 5'd4;
        run_round(p, 1'b1);

        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) begin
                if (t % 3 == 0) p[i*W +: W] = W'($urandom_range(6, 10));
                else            p[i*W +: W] = W'($urandom_range(0, 31));
            end
            run_round(p, (t % 7) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

endmodule